// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Presenter

This block holds the interrupt presentation state of one processor. It keeps an eight-bit vector of pending priority levels, a current processor priority (`cppr`) that masks every level numerically at or above it, and an inter-processor request priority (`mfrr`) that software writes to ask for an IPI. Level 0 is the most favoured and level 7 the least; a value of 0xFF in `cppr` masks nothing, and 0xFF in `mfrr` requests nothing.

Each cycle the block picks a winner from its registered state. The best queued level is the lowest set bit of the pending vector, and it can be delivered only while it is below `cppr`. The IPI competes with it and takes precedence when `mfrr` is below `cppr` and not numerically above the best queued level. The interrupt line, the acknowledge word and the packed result word are all combinational views of that choice. An acknowledge strobe consumes the winner: `cppr` takes the winning level, and a queued winner leaves the pending vector. The result word puts the delivered interrupt number in its low 24 bits and the `cppr` held before the acknowledge in its top byte.

Top module: `prio_presenter`

## Requirements
- R1: After reset the pending vector is empty, `cppr` is 0x00 and `mfrr` is 0xFF, so `irq_o` is 0, `ack_word_o` is 0x0000 and `result_o` is 0x00000000.
- R2: `note_vld` with level `note_prio` sets that pending bit at the next edge; a pending level asserts `irq_o` only while it is numerically below `cppr`.
- R3: Among several pending levels the lowest-numbered set bit is the queued candidate.
- R4: The IPI wins when `mfrr < cppr` and `mfrr` is less than or equal to the best pending level (any value counts as less than or equal when nothing is pending); the IPI interrupt number is `IPI_NUM` (default 2).
- R5: `ack_word_o` is {0x80, winning level} when a winner exists (bit 15 is the event flag) and {0x00, `cppr`} otherwise. An `ack_rd` strobe with a winner loads `cppr` with the winning level at the next edge and, when the winner is queued, clears that pending bit; the IPI winner clears nothing.
- R6: `result_o` = interrupt number | (`cppr` << 24), where the number is `IPI_NUM` for an IPI, `QUEUE_BASE + level` (default 16) for a queued winner, and 0 when nothing is deliverable.
- R7: `spend_we` with `spend_wdata` below 8 sets that pending bit; a value from 8 to 0xFE sets bit 7; 0xFF changes nothing.
- R8: `cppr_we` loads `cppr` at the next edge and `irq_o` reflects the new mask in the cycle the register changes; a `cppr` write takes precedence over the `cppr` update of a simultaneous acknowledge.
- R9: A notification for the same level that a simultaneous acknowledge consumes leaves that pending bit set.
- R10: `mfrr_we` loads `mfrr` at the next edge; an `mfrr` of 0xFF never produces an IPI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| note_vld | input | 1 | Queued-level notification strobe |
| note_prio | input | 3 | Level being notified |
| cppr_we | input | 1 | Processor priority write strobe |
| cppr_wdata | input | 8 | New processor priority |
| mfrr_we | input | 1 | IPI request priority write strobe |
| mfrr_wdata | input | 8 | New IPI request priority |
| spend_we | input | 1 | Software set-pending strobe |
| spend_wdata | input | 8 | Priority to mark pending |
| ack_rd | input | 1 | Acknowledge strobe, consumes the current winner |
| irq_o | output | 1 | A deliverable interrupt exists |
| ack_word_o | output | 16 | Event flag byte and acknowledged level |
| result_o | output | 32 | Old processor priority in the top byte, interrupt number below |

## Verification
An acknowledge can land in the same cycle as a notification, a set-pending write or a `cppr` write, so the consume-and-clear and the set-or-overwrite paths collide on the same register. The bench provokes this both with directed cases (a notification for the very level being consumed, a `cppr` write racing an acknowledge) and with random cycles where every strobe fires independently. It judges each collision by the next cycle's outputs against a bench model that applies clear before set and write before acknowledge.

// File: rtl/presenter_pkg.sv
package presenter_pkg;
    parameter int NPRIO  = 8;
    parameter int PRIO_W = $clog2(NPRIO);

    typedef struct packed {
        logic [NPRIO-1:0] pend;
        logic [7:0]       cppr;
        logic [7:0]       mfrr;
    } pstate_t;

    localparam logic [7:0] PRIO_NONE = 8'hFF;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/win_select.sv
module win_select
    import presenter_pkg::*;
(
    input  logic              q_found,
    input  logic [PRIO_W-1:0] q_idx,
    input  logic [7:0]        cppr,
    input  logic [7:0]        mfrr,
    output logic              q_ok,
    output logic              ipi_ok,
    output logic [7:0]        win_prio
);
    logic [7:0] q_best;

    always_comb begin
        q_best   = q_found ? 8'(q_idx) : PRIO_NONE;
        q_ok     = q_found && (q_best < cppr);
        ipi_ok   = (mfrr < cppr) && (mfrr <= q_best);
        win_prio = ipi_ok ? mfrr : (q_ok ? q_best : cppr);
    end
endmodule

// File: rtl/prio_presenter.sv
module prio_presenter
    import presenter_pkg::*;
#(
    parameter int IPI_NUM    = 2,
    parameter int QUEUE_BASE = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        note_vld,
    input  logic [2:0]  note_prio,
    input  logic        cppr_we,
    input  logic [7:0]  cppr_wdata,
    input  logic        mfrr_we,
    input  logic [7:0]  mfrr_wdata,
    input  logic        spend_we,
    input  logic [7:0]  spend_wdata,
    input  logic        ack_rd,
    output logic        irq_o,
    output logic [15:0] ack_word_o,
    output logic [31:0] result_o
);
    pstate_t st_q, st_d;

    logic              q_found;
    logic [PRIO_W-1:0] q_idx;
    logic              q_ok, ipi_ok;
    logic [7:0]        win_prio;
    logic [23:0]       irq_num;
    logic [NPRIO-1:0]  clr_vec, set_vec;

    prio_pick #(.N(NPRIO)) u_pick (
        .vec   (st_q.pend),
        .found (q_found),
        .idx   (q_idx)
    );

    win_select u_sel (
        .q_found  (q_found),
        .q_idx    (q_idx),
        .cppr     (st_q.cppr),
        .mfrr     (st_q.mfrr),
        .q_ok     (q_ok),
        .ipi_ok   (ipi_ok),
        .win_prio (win_prio)
    );

    always_comb begin
        irq_num = '0;
        if (ipi_ok)
            irq_num = 24'(IPI_NUM);
        else if (q_ok)
            irq_num = 24'(QUEUE_BASE) + 24'(q_idx);

        irq_o      = q_ok || ipi_ok;
        ack_word_o = {(irq_o ? 8'h80 : 8'h00), win_prio};
        result_o   = {st_q.cppr, irq_num};
    end

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        set_vec = '0;

        if (ack_rd && irq_o) begin
            st_d.cppr = win_prio;
            if (!ipi_ok)
                clr_vec[q_idx] = 1'b1;
        end
        if (note_vld)
            set_vec[note_prio] = 1'b1;
        if (spend_we && spend_wdata != PRIO_NONE) begin
            if (spend_wdata < 8'(NPRIO))
                set_vec[spend_wdata[PRIO_W-1:0]] = 1'b1;
            else
                set_vec[NPRIO-1] = 1'b1;
        end
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;

        if (cppr_we)
            st_d.cppr = cppr_wdata;
        if (mfrr_we)
            st_d.mfrr = mfrr_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.cppr <= 8'h00;
            st_q.mfrr <= PRIO_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: a processor priority write lands at the next edge
    assert_cppr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cppr_we |=> st_q.cppr == $past(cppr_wdata));

    // R5: an acknowledge without a racing write takes the acknowledged level
    assert_ack_cppr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && ack_word_o[15] && !cppr_we) |=> st_q.cppr == $past(ack_word_o[7:0]));

    // R9: a notified level is pending after the edge, whatever else happens
    assert_note_sticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        note_vld |=> st_q.pend[$past(note_prio)]);

    // R7: an out-of-range set-pending value lands on the least favoured level
    assert_spend_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (spend_we && spend_wdata >= 8'(NPRIO) && spend_wdata != PRIO_NONE)
            |=> st_q.pend[NPRIO-1]);

    // R4: a request below the mask always raises the line
    assert_ipi_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mfrr < st_q.cppr) |-> irq_o);

    // R10: a cleared request never shows the IPI number
    assert_no_ipi_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mfrr == PRIO_NONE) |-> result_o[23:0] != 24'(IPI_NUM));
endmodule

// File: tb/prio_presenter_tb.sv
module prio_presenter_tb;
    localparam int IPI_NUM    = 2;
    localparam int QUEUE_BASE = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        note_vld;
    logic [2:0]  note_prio;
    logic        cppr_we;
    logic [7:0]  cppr_wdata;
    logic        mfrr_we;
    logic [7:0]  mfrr_wdata;
    logic        spend_we;
    logic [7:0]  spend_wdata;
    logic        ack_rd;
    logic        irq_o;
    logic [15:0] ack_word_o;
    logic [31:0] result_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [7:0] m_pend, m_cppr, m_mfrr;

    always #2 clk = ~clk;

    prio_presenter #(.IPI_NUM(IPI_NUM), .QUEUE_BASE(QUEUE_BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .note_vld(note_vld), .note_prio(note_prio),
        .cppr_we(cppr_we), .cppr_wdata(cppr_wdata), .mfrr_we(mfrr_we),
        .mfrr_wdata(mfrr_wdata), .spend_we(spend_we), .spend_wdata(spend_wdata),
        .ack_rd(ack_rd), .irq_o(irq_o), .ack_word_o(ack_word_o), .result_o(result_o)
    );

    function automatic int best_of(input logic [7:0] p);
        for (int i = 0; i < 8; i++)
            if (p[i]) return i;
        return 255;
    endfunction

    function automatic bit ipi_wins();
        return (m_mfrr < m_cppr) && (int'(m_mfrr) <= best_of(m_pend));
    endfunction

    function automatic bit q_wins();
        return !ipi_wins() && best_of(m_pend) < int'(m_cppr);
    endfunction

    function automatic logic [15:0] exp_ack();
        if (ipi_wins()) return {8'h80, m_mfrr};
        if (q_wins())   return {8'h80, 8'(best_of(m_pend))};
        return {8'h00, m_cppr};
    endfunction

    function automatic logic [31:0] exp_result();
        logic [23:0] n;
        n = 24'd0;
        if (ipi_wins())    n = 24'(IPI_NUM);
        else if (q_wins()) n = 24'(QUEUE_BASE + best_of(m_pend));
        return {m_cppr, n};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " irq"}, 32'(irq_o), 32'(ipi_wins() || q_wins()));
        check({tag, " ack"}, 32'(ack_word_o), 32'(exp_ack()));
        check({tag, " result"}, result_o, exp_result());
    endtask

    task automatic clear_inputs();
        note_vld = 0; note_prio = 0; cppr_we = 0; cppr_wdata = 0;
        mfrr_we = 0; mfrr_wdata = 0; spend_we = 0; spend_wdata = 0; ack_rd = 0;
    endtask

    task automatic model_edge();
        logic [7:0] clr, set;
        logic [7:0] nc;
        clr = 0; set = 0; nc = m_cppr;
        if (ack_rd && (ipi_wins() || q_wins())) begin
            if (ipi_wins()) nc = m_mfrr;
            else begin
                nc = 8'(best_of(m_pend));
                clr[best_of(m_pend)] = 1'b1;
            end
        end
        if (note_vld) set[note_prio] = 1'b1;
        if (spend_we && spend_wdata != 8'hFF) begin
            if (spend_wdata < 8) set[spend_wdata[2:0]] = 1'b1;
            else set[7] = 1'b1;
        end
        if (cppr_we) nc = cppr_wdata;
        m_pend = (m_pend & ~clr) | set;
        m_cppr = nc;
        if (mfrr_we) m_mfrr = mfrr_wdata;
    endtask

    // inputs already driven just after a falling edge; apply one edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        clear_inputs();
        #1;
    endtask

    function automatic logic [7:0] pick_level();
        int r;
        r = int'($urandom_range(0, 11));
        if (r < 10) return 8'(r);
        if (r == 10) return 8'hFF;
        return 8'($urandom_range(8, 254));
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_inputs();
        rst_n = 0;
        m_pend = 0; m_cppr = 8'h00; m_mfrr = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check("R1 irq", 32'(irq_o), 32'd0);
        check("R1 ack", 32'(ack_word_o), 32'h0000);
        check("R1 result", result_o, 32'h0);

        // R2 pending level masked by cppr 0
        note_vld = 1; note_prio = 3; step();
        check("R2 masked irq", 32'(irq_o), 32'd0);
        cppr_we = 1; cppr_wdata = 8'd3; step();
        check("R2 equal mask irq", 32'(irq_o), 32'd0);
        // R8 raising the mask exposes it in the cycle cppr changes
        cppr_we = 1; cppr_wdata = 8'd4; step();
        check("R8 unmask irq", 32'(irq_o), 32'd1);
        check("R2 ack", 32'(ack_word_o), 32'h8003);
        check("R6 result", result_o, 32'h0400_0013);

        // R3 lowest set bit wins
        cppr_we = 1; cppr_wdata = 8'hFF; note_vld = 1; note_prio = 6; step();
        spend_we = 1; spend_wdata = 8'd1; step();
        check("R3 best level", 32'(ack_word_o), 32'h8001);
        check_all("R7 spend");

        // R4 IPI ties with best queued level and wins
        mfrr_we = 1; mfrr_wdata = 8'd1; step();
        check("R4 ipi tie", result_o, 32'hFF00_0002);
        // R5 ack IPI: cppr <- 1, pending untouched
        ack_rd = 1; step();
        check("R5 ipi ack cppr", 32'(result_o[31:24]), 32'd1);
        check("R5 ipi ack masked", 32'(irq_o), 32'd0);
        // R10 clear request, reopen mask: queued 1 still pending
        mfrr_we = 1; mfrr_wdata = 8'hFF; cppr_we = 1; cppr_wdata = 8'hFF; step();
        check("R10 queued after ipi", 32'(ack_word_o), 32'h8001);
        check("R10 result no ipi", result_o, 32'hFF00_0011);

        // R5 ack queued level 1: bit cleared, next best is 3
        ack_rd = 1; step();
        check("R5 ack cppr", 32'(ack_word_o), 32'h0001);
        cppr_we = 1; cppr_wdata = 8'hFF; step();
        check("R5 bit cleared", 32'(ack_word_o), 32'h8003);

        // R9 notify same level being consumed
        ack_rd = 1; note_vld = 1; note_prio = 3; step();
        cppr_we = 1; cppr_wdata = 8'hFF; step();
        check("R9 level kept", 32'(ack_word_o), 32'h8003);

        // R8 cppr write beats ack
        ack_rd = 1; cppr_we = 1; cppr_wdata = 8'd7; step();
        check("R8 write beats ack", 32'(result_o[31:24]), 32'd7);
        check_all("R8 after race");

        // R7 out-of-range maps to 7, 0xFF ignored
        rst_n = 0; step(); rst_n = 1;
        m_pend = 0; m_cppr = 8'h00; m_mfrr = 8'hFF;
        cppr_we = 1; cppr_wdata = 8'hFF; spend_we = 1; spend_wdata = 8'hFF; step();
        check("R7 0xFF ignored", 32'(irq_o), 32'd0);
        spend_we = 1; spend_wdata = 8'd200; step();
        check("R7 high maps to 7", 32'(ack_word_o), 32'h8007);
        // R10 mfrr 0xFE below cppr 0xFF with only 7 pending loses to 7
        mfrr_we = 1; mfrr_wdata = 8'hFE; step();
        check("R10 large mfrr loses", result_o, 32'hFF00_0017);

        // random mix, R3 R4 R5 R6 against the model
        for (int k = 0; k < 3000; k++) begin
            note_vld    = ($urandom_range(0, 9) < 3);
            note_prio   = 3'($urandom_range(0, 7));
            cppr_we     = ($urandom_range(0, 9) < 2);
            cppr_wdata  = pick_level();
            mfrr_we     = ($urandom_range(0, 9) < 1);
            mfrr_wdata  = pick_level();
            spend_we    = ($urandom_range(0, 19) < 1);
            spend_wdata = pick_level();
            ack_rd      = ($urandom_range(0, 9) < 3);
            check_all("R6 random");
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule